// File: doc/BRIEF.md
# Radio module power sequencer

This block switches an attached radio module on and off in a fixed order, with a timed pause at each step. A power-on request starts the bring-up. Reset and the wake pin are held low for a settle pause. The supply rails are then switched on, and one cycle later the low-frequency clock enable follows. After a clock-stabilisation pause the wake pin rises. After a longer wake pause reset is released, and after a final boot pause the block reports ready.

A power-off request may come during bring-up or while ready. The block pulls reset low and changes nothing else for a hold period. It then drops the rails and the wake pin together, drops the clock enable one cycle later, and returns to off.

All pauses are counted in milliseconds. A prescaler turns the system clock into a millisecond tick. The tick length and every pause are parameters, so a test setup can shorten them.

Top module: `radio_pwr_seq`

## Requirements
- R1: While reset is asserted, and after it, until a power-on request arrives, rail_en, lpclk_en, wake_o, rst_n_o and ready are all 0, and busy is 0.
- R2: A power-on request accepted in the off state starts a settle pause lasting SETTLE_MS*TICK_CYC cycles. During the pause busy is 1 and all four control outputs stay 0.
- R3: When the settle pause ends, rail_en goes to 1. lpclk_en follows exactly one cycle later.
- R4: lpclk_en is held for CLKSTB_MS*TICK_CYC cycles before wake_o goes to 1.
- R5: wake_o is held for WAKE_MS*TICK_CYC cycles before rst_n_o goes to 1. After a further BOOT_MS*TICK_CYC cycles, ready goes to 1 and busy goes to 0.
- R6: rst_n_o is 1 only while rail_en, lpclk_en and wake_o are all 1. ready is 1 only while rst_n_o is 1. ready and busy are never 1 together.
- R7: A power-off request during bring-up or while ready drives rst_n_o to 0 in the next cycle and drops ready. rail_en, lpclk_en and wake_o keep their values for HOLD_MS*TICK_CYC cycles, and busy is 1.
- R8: When the hold ends, rail_en and wake_o drop together. lpclk_en drops one cycle later, and busy goes to 0 in the same cycle.
- R9: A power-on request has no effect while busy or ready. A power-off request has no effect in the off state or during teardown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Power-on request, sampled each cycle |
| off_req | input | 1 | Power-off request, sampled each cycle |
| rail_en | output | 1 | Enable for the module's supply rails |
| lpclk_en | output | 1 | Enable for the low-frequency clock |
| wake_o | output | 1 | Wake pin of the module, active high |
| rst_n_o | output | 1 | Reset pin of the module, active low |
| ready | output | 1 | Module is up and usable |
| busy | output | 1 | A bring-up or teardown is in progress |

## Verification
Full bring-ups are compared cycle by cycle against a computed timeline, which pins down each pause length and the one-cycle gap between rail and clock. Aborts are directed at the first settle cycle, at the rail-to-clock boundary and from the ready state. Further aborts land at random points, which shows whether the hold keeps the rail, clock and wake levels that were current when the abort arrived. Random stray on and off pulses are mixed into busy, ready and teardown periods, and a stray off pulse is given in the off state; any reaction to them is a visible output change.

// File: rtl/radio_pwr_seq.sv
module radio_pwr_seq #(
  parameter int TICK_CYC  = 50000,
  parameter int SETTLE_MS = 10,
  parameter int CLKSTB_MS = 10,
  parameter int WAKE_MS   = 250,
  parameter int BOOT_MS   = 50,
  parameter int HOLD_MS   = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_req,
  input  logic off_req,
  output logic rail_en,
  output logic lpclk_en,
  output logic wake_o,
  output logic rst_n_o,
  output logic ready,
  output logic busy
);
  localparam int MAXA = (SETTLE_MS > CLKSTB_MS) ? SETTLE_MS : CLKSTB_MS;
  localparam int MAXB = (WAKE_MS > BOOT_MS) ? WAKE_MS : BOOT_MS;
  localparam int MAXC = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int MAXMS = (MAXC > HOLD_MS) ? MAXC : HOLD_MS;
  localparam int MSW = $clog2(MAXMS + 1);
  localparam int PW  = $clog2(TICK_CYC + 1);

  typedef enum logic [3:0] {
    S_OFF, S_SETTLE, S_RAIL, S_CLKW, S_WAKE, S_BOOT, S_READY, S_HOLD, S_DROP
  } st_t;

  st_t st, nxt;
  logic [PW-1:0]  pre;
  logic [MSW-1:0] ms, lim;
  logic tick, done, up_phase;

  always_comb begin
    case (st)
      S_SETTLE: lim = MSW'(SETTLE_MS);
      S_CLKW:   lim = MSW'(CLKSTB_MS);
      S_WAKE:   lim = MSW'(WAKE_MS);
      S_BOOT:   lim = MSW'(BOOT_MS);
      S_HOLD:   lim = MSW'(HOLD_MS);
      default:  lim = MSW'(1);
    endcase
  end

  assign tick = (pre == PW'(TICK_CYC - 1));
  assign done = tick && (ms == lim - MSW'(1));
  assign up_phase = (st != S_OFF) && (st != S_HOLD) && (st != S_DROP);

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:    if (on_req) nxt = S_SETTLE;
      S_SETTLE: if (done) nxt = S_RAIL;
      S_RAIL:   nxt = S_CLKW;
      S_CLKW:   if (done) nxt = S_WAKE;
      S_WAKE:   if (done) nxt = S_BOOT;
      S_BOOT:   if (done) nxt = S_READY;
      S_HOLD:   if (done) nxt = S_DROP;
      S_DROP:   nxt = S_OFF;
      default:  nxt = st;
    endcase
    if (off_req && up_phase) nxt = S_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      pre      <= '0;
      ms       <= '0;
      rail_en  <= 1'b0;
      lpclk_en <= 1'b0;
      wake_o   <= 1'b0;
      rst_n_o  <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st) begin
        pre <= '0;
        ms  <= '0;
      end else if (tick) begin
        pre <= '0;
        ms  <= ms + MSW'(1);
      end else begin
        pre <= pre + PW'(1);
      end
      if (nxt != S_HOLD) begin
        rail_en  <= nxt inside {S_RAIL, S_CLKW, S_WAKE, S_BOOT, S_READY};
        lpclk_en <= (nxt inside {S_CLKW, S_WAKE, S_BOOT, S_READY}) ||
                    (nxt == S_DROP && lpclk_en);
        wake_o   <= nxt inside {S_WAKE, S_BOOT, S_READY};
      end
      rst_n_o <= nxt inside {S_BOOT, S_READY};
    end
  end

  assign ready = (st == S_READY);
  assign busy  = up_phase && (st != S_READY) || (st == S_HOLD) || (st == S_DROP);
endmodule

// File: rtl/radio_pwr_seq_chk.sv
module radio_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic rail_en,
  input logic lpclk_en,
  input logic wake_o,
  input logic rst_n_o,
  input logic ready,
  input logic busy
);
  a_r3_clk_after_rail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpclk_en) |-> rail_en && $past(rail_en));
  a_r4_wake_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_o) |-> lpclk_en && $past(lpclk_en));
  a_r5_release_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_o) |-> wake_o && $past(wake_o));
  a_r6_rst_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n_o |-> rail_en && lpclk_en && wake_o);
  a_r6_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && busy) && (!ready || rst_n_o));
  a_r7_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_n_o) |-> $stable(rail_en) && $stable(wake_o) && $stable(lpclk_en));
  a_r8_rail_drop_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_en) |-> !rst_n_o && $past(!rst_n_o));
  a_r8_clk_drops_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lpclk_en) |-> !rail_en && !wake_o && !busy);
endmodule

bind radio_pwr_seq radio_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .lpclk_en(lpclk_en),
  .wake_o(wake_o), .rst_n_o(rst_n_o), .ready(ready), .busy(busy)
);

// File: tb/tb_radio_pwr_seq.sv
module tb_radio_pwr_seq;
  localparam int P = 4, SET = 2, CS = 3, WK = 5, BT = 2, HD = 3;
  localparam int T_RAIL = SET * P;
  localparam int T_CLK  = T_RAIL + 1;
  localparam int T_WAKE = T_CLK + CS * P;
  localparam int T_BOOT = T_WAKE + WK * P;
  localparam int T_RDY  = T_BOOT + BT * P;
  localparam int TH     = HD * P;

  logic clk = 1'b0, rst_n = 1'b0, on_req = 1'b0, off_req = 1'b0;
  logic rail_en, lpclk_en, wake_o, rst_n_o, ready, busy;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  radio_pwr_seq #(.TICK_CYC(P), .SETTLE_MS(SET), .CLKSTB_MS(CS), .WAKE_MS(WK),
                  .BOOT_MS(BT), .HOLD_MS(HD)) dut (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .rail_en(rail_en), .lpclk_en(lpclk_en), .wake_o(wake_o),
    .rst_n_o(rst_n_o), .ready(ready), .busy(busy));

  // {rail, clk, wake, nrst, ready, busy}
  function automatic logic [5:0] bring(int t);
    if (t < T_RAIL) return 6'b000001;
    if (t < T_CLK)  return 6'b100001;
    if (t < T_WAKE) return 6'b110001;
    if (t < T_BOOT) return 6'b111001;
    if (t < T_RDY)  return 6'b111101;
    return 6'b111110;
  endfunction

  function automatic logic [5:0] expect_at(int t, int d);
    logic [5:0] p;
    if (t < d) return bring(t);
    p = bring(d - 1);
    if (t - d < TH) return {p[5], p[4], p[3], 3'b001};
    if (t - d == TH) return {1'b0, p[4], 4'b0001};
    return 6'b000000;
  endfunction

  function automatic string tag(int t, int d);
    if (t >= d) return (t - d < TH) ? "R7" : "R8";
    if (t < T_RAIL) return "R2";
    if (t < T_WAKE) return "R3";
    if (t < T_BOOT) return "R4";
    return "R5";
  endfunction

  task automatic compare(logic [5:0] exp_v, string req);
    logic [5:0] act;
    act = {rail_en, lpclk_en, wake_o, rst_n_o, ready, busy};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp_v, $time);
    end
  endtask

  // d: cycles from the accepted on edge to the off edge; noise adds stray pulses (R9)
  task automatic run_seq(int d, int len, bit noise);
    @(negedge clk) on_req = 1'b1;
    @(negedge clk) on_req = 1'b0;
    for (int k = 0; k <= len; k++) begin
      compare(expect_at(k, d), tag(k, d));
      off_req = (k + 1 == d);
      on_req  = 1'b0;
      if (noise && k + 1 <= d + TH - 2) begin
        on_req = ($urandom % 3 == 0);
        if (k + 1 > d) off_req = ($urandom % 3 == 0);
      end
      @(negedge clk);
    end
    on_req = 1'b0;
    off_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    compare(6'b000000, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare(6'b000000, "R1");
    off_req = 1'b1;
    @(negedge clk) off_req = 1'b0;
    repeat (2) @(negedge clk);
    compare(6'b000000, "R9");
    run_seq(T_RDY + 8, T_RDY + 8 + TH + 4, 1'b0);
    run_seq(1, TH + 4, 1'b0);
    run_seq(T_RAIL, T_RAIL + TH + 4, 1'b0);
    run_seq(T_CLK, T_CLK + TH + 4, 1'b0);
    run_seq(T_WAKE + 1, T_WAKE + TH + 5, 1'b1);
    run_seq(T_RDY + 3, T_RDY + TH + 7, 1'b1);
    for (int i = 0; i < 30; i++) begin
      int d;
      d = 1 + int'($urandom % (T_RDY + 6));
      run_seq(d, d + TH + 3, 1'b1);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule